// File: doc/BRIEF.md
# Strap Capture and Frequency Code Selector

This block sits between a clock generator's dual-purpose pads and its synthesis core. While power-on reset is held, a group of five shared pads acts as configuration inputs. Once reset has been released and brought in line with the clock, the block samples the pads a single time and holds the result. It then turns the pads into outputs so they can carry clocks. Nothing seen on the pads after that point changes the captured value until the next reset.

Four of the captured bits form the hardware frequency code. The fifth bit is an auxiliary strap that only goes to readback. An 8-bit control byte from the register file chooses whether the effective frequency code comes from the straps or from a software code. It also carries the spread-spectrum enable, the spread shape and a global high-impedance request.

Every control output is registered, so a control byte rewritten in the middle of a bus transfer reaches the core one clock later and without glitches. The captured straps are always available for readback.

Top module: `strap_fsel_top`

## Requirements
- R1: While rst_n is low, pin_oe_o is all zeros and fsel_o, ss_en_o, ss_down_o, out_hiz_o and strap_rb_o are all zero.
- R2: rst_n is released through a two-stage synchronizer. At the third rising clock edge after rst_n rises, strap_pin_i is captured into strap_rb_o and pin_oe_o becomes all ones. Before that edge pin_oe_o stays zero.
- R3: After capture, changes on strap_pin_i have no effect on strap_rb_o until the next reset.
- R4: When ctrl_i bit 3 is 0, fsel_o equals strap_rb_o[3:0] (bit 3 is the most significant) one clock after ctrl_i is applied.
- R5: When ctrl_i bit 3 is 1, fsel_o equals {ctrl_i[2], ctrl_i[6], ctrl_i[5], ctrl_i[4]} one clock later, with ctrl_i[2] as the most significant bit.
- R6: ss_en_o follows ctrl_i bit 1 one clock later.
- R7: ss_down_o follows ctrl_i bit 7 one clock later. A value of 1 means down spread of 0 to -0.5%, and 0 means centre spread of ±0.25%.
- R8: out_hiz_o follows ctrl_i bit 0 one clock later. When it is 1, all clock outputs are to float.
- R9: A new reset clears the capture, and the next release captures the pad levels again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| strap_pin_i | input | 5 | Pad levels of the shared pins; [3:0] frequency code, [4] auxiliary strap |
| ctrl_i | input | 8 | Control byte from the register file |
| pin_oe_o | output | 5 | Pad output enable, 1 once straps are captured |
| fsel_o | output | 4 | Effective frequency code |
| ss_en_o | output | 1 | Spread-spectrum enable |
| ss_down_o | output | 1 | Spread shape, 1 for down spread |
| out_hiz_o | output | 1 | Global output float request |
| strap_rb_o | output | 5 | Captured strap value for readback |

## Verification
The bench changes the pad levels after capture and checks that the readback and the strap-sourced code stay put. A latch that kept sampling would follow the pads instead. It checks that the pads stay inputs through the second synchronizer edge and turn at the third, which exposes a missing or extra synchronizer stage. Software codes are chosen so that each scattered control bit lands in a distinct position, so a swapped or reversed code field produces a different value. A second reset with a different strap pattern shows that the latch re-arms rather than keeping the stale capture.

// File: rtl/strap_fsel_pkg.sv
package strap_fsel_pkg;
  localparam int STRAP_W = 5;
  localparam int FS_W    = 4;
  localparam int CTRL_W  = 8;
  // control byte field positions (decoded by the register file)
  localparam int C_HIZ   = 0;
  localparam int C_SSEN  = 1;
  localparam int C_FS3   = 2;
  localparam int C_SRC   = 3;
  localparam int C_FS0   = 4;
  localparam int C_FS1   = 5;
  localparam int C_FS2   = 6;
  localparam int C_SSDN  = 7;

  typedef struct packed {
    logic [FS_W-1:0] fsel;
    logic            ss_en;
    logic            ss_down;
    logic            hiz;
  } sel_out_t;
endpackage

// File: rtl/strap_rst_sync.sv
module strap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/strap_latch.sv
module strap_latch #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] strap_q,
  output logic         captured_q,
  output logic [W-1:0] oe_o
);
  logic [W-1:0] strap_d;
  logic         cap_en;

  assign cap_en = ~captured_q;

  always_comb begin
    strap_d = strap_q;
    if (cap_en) strap_d = pin_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_q    <= '0;
      captured_q <= 1'b0;
    end else begin
      strap_q    <= strap_d;
      captured_q <= 1'b1;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_oe
    assign oe_o[i] = captured_q;
  end

  // R3
  strap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    captured_q |=> $stable(strap_q));
  // R2
  single_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !captured_q |=> (captured_q && strap_q == $past(pin_i)));
endmodule

// File: rtl/strap_sel_stage.sv
module strap_sel_stage
  import strap_fsel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [FS_W-1:0]   strap_fs_i,
  output sel_out_t          out_q
);
  sel_out_t out_d;
  logic [FS_W-1:0] sw_code;

  assign sw_code = {ctrl_i[C_FS3], ctrl_i[C_FS2], ctrl_i[C_FS1], ctrl_i[C_FS0]};

  always_comb begin
    out_d = out_q;
    if (en_i) begin
      out_d.fsel    = ctrl_i[C_SRC] ? sw_code : strap_fs_i;
      out_d.ss_en   = ctrl_i[C_SSEN];
      out_d.ss_down = ctrl_i[C_SSDN];
      out_d.hiz     = ctrl_i[C_HIZ];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

  // R4
  strap_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !ctrl_i[C_SRC]) |=> out_q.fsel == $past(strap_fs_i));
  // R6
  ss_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> out_q.ss_en == $past(ctrl_i[C_SSEN]));
  // R8
  hiz_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> out_q.hiz == $past(ctrl_i[C_HIZ]));
  // R4
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(out_q));
endmodule

// File: rtl/strap_fsel_top.sv
module strap_fsel_top
  import strap_fsel_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap_pin_i,
  input  logic [CTRL_W-1:0]  ctrl_i,
  output logic [STRAP_W-1:0] pin_oe_o,
  output logic [FS_W-1:0]    fsel_o,
  output logic               ss_en_o,
  output logic               ss_down_o,
  output logic               out_hiz_o,
  output logic [STRAP_W-1:0] strap_rb_o
);
  logic               srst_n;
  logic [STRAP_W-1:0] strap_q;
  logic               captured;
  sel_out_t           sel_q;

  strap_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  strap_latch #(.W(STRAP_W)) u_latch (
    .clk        (clk),
    .rst_n      (srst_n),
    .pin_i      (strap_pin_i),
    .strap_q    (strap_q),
    .captured_q (captured),
    .oe_o       (pin_oe_o)
  );

  strap_sel_stage u_sel (
    .clk        (clk),
    .rst_n      (srst_n),
    .en_i       (captured),
    .ctrl_i     (ctrl_i),
    .strap_fs_i (strap_q[FS_W-1:0]),
    .out_q      (sel_q)
  );

  assign fsel_o     = sel_q.fsel;
  assign ss_en_o    = sel_q.ss_en;
  assign ss_down_o  = sel_q.ss_down;
  assign out_hiz_o  = sel_q.hiz;
  assign strap_rb_o = strap_q;

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (pin_oe_o == '0 && strap_rb_o == '0 && fsel_o == '0);
    end
  end
  // R7
  down_follow_chk: assert property (@(posedge clk) disable iff (!srst_n)
    captured |=> ss_down_o == $past(ctrl_i[C_SSDN]));
  // R5
  sw_code_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (captured && ctrl_i[C_SRC]) |=>
      fsel_o == {$past(ctrl_i[C_FS3]), $past(ctrl_i[C_FS2]),
                 $past(ctrl_i[C_FS1]), $past(ctrl_i[C_FS0])});
endmodule

// File: tb/strap_fsel_top_bench.sv
module strap_fsel_top_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] pins;
  logic [7:0] ctrl;
  logic [4:0] oe, rb;
  logic [3:0] fsel;
  logic       ss_en, ss_down, hiz;
  int checks = 0, failures = 0;
  bit done = 0;

  logic [11:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  strap_fsel_top u_strap_fsel_top (
    .clk(clk), .rst_n(rst_n), .strap_pin_i(pins), .ctrl_i(ctrl),
    .pin_oe_o(oe), .fsel_o(fsel), .ss_en_o(ss_en), .ss_down_o(ss_down),
    .out_hiz_o(hiz), .strap_rb_o(rb));

  task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [11:0] model(logic [7:0] c, logic [4:0] s);
    logic [3:0] f;
    f = c[3] ? {c[2], c[6], c[5], c[4]} : s[3:0];
    return {f, c[1], c[7], c[0], s};
  endfunction

  // driver: apply control at a falling edge, queue the expected outputs
  task automatic drive(logic [7:0] c, logic [4:0] held, string tag);
    @(negedge clk);
    ctrl = c;
    exp_q.push_back(model(c, held));
    tag_q.push_back(tag);
  endtask

  // monitor: compare just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [11:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {fsel, ss_en, ss_down, hiz, rb}, e);
      end
    end
  end

  task automatic do_reset(logic [4:0] p, string tag);
    @(negedge clk);
    rst_n = 1'b0;
    pins  = p;
    ctrl  = 8'h00;
    @(negedge clk);
    check({tag, " R1 oe in reset"}, oe, 5'h00);
    check({tag, " R1 outputs in reset"}, {fsel, ss_en, ss_down, hiz, rb}, 12'h000);
    rst_n = 1'b1;
    @(posedge clk); #2;
    @(posedge clk); #2;
    check({tag, " R2 oe before capture"}, oe, 5'h00);
    @(posedge clk); #2;
    check({tag, " R2 captured straps"}, rb, p);
    check({tag, " R2 oe after capture"}, oe, 5'h1f);
  endtask

  initial begin
    rst_n = 1'b0;
    pins  = 5'h00;
    ctrl  = 8'h00;
    repeat (3) @(negedge clk);
    do_reset(5'b10110, "first");
    @(negedge clk);
    pins = 5'b01001;
    drive(8'h00, 5'b10110, "R3 R4 strap code after pin change");
    drive(8'h3C, 5'b10110, "R5 sw code 1011");
    drive(8'h48, 5'b10110, "R5 sw code 0100");
    drive(8'h7C, 5'b10110, "R5 sw code 1111");
    drive(8'h82, 5'b10110, "R6 R7 down spread on");
    drive(8'h02, 5'b10110, "R6 R7 centre spread on");
    drive(8'h01, 5'b10110, "R8 float request");
    drive(8'h00, 5'b10110, "R3 R8 float release");
    repeat (3) @(negedge clk);
    do_reset(5'b01001, "second R9");
    drive(8'h00, 5'b01001, "R9 R4 new strap code");
    drive(8'h8B, 5'b01001, "R9 R5 sw code 0000");
    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule